// File: doc/BRIEF.md
# Ethernet Pause Frame Request Controller

This block sits between a client transmit stream and a MAC transmitter and decides when flow-control pause frames must go out on the link. An XOFF pause frame asks the link partner to stop sending and carries a nonzero pause time. An XON pause frame releases the partner and carries a pause time of zero. Requests arrive from three sources. The client can pulse a strobe for one cycle. The host can set a self-clearing control bit. The local receive FIFO raises or drops its almost-full flag.

All requests are merged into a single pending slot that remembers which kind was raised most recently. The block never cuts into a data frame. A pending request waits until the client frame in flight has delivered its end beat. The block then stalls the client by lowering ready and drives a minimum-size pause frame onto the 64-bit output stream. That frame is 60 bytes before the frame check sequence, which is appended further downstream. When the last pause beat has gone out, the client path is reconnected.

Top module: `eth_pause_ctrl`

## Requirements
- R1: After reset, `cl_ready_o` is 1, `tx_valid_o` is 0 while the client is idle, and both host readback bits are 0.
- R2: A one-cycle pulse on `cl_xoff_req_i` produces exactly one XOFF pause frame whose quanta field equals `xoff_quanta_i`.
- R3: A one-cycle pulse on `cl_xon_req_i` produces exactly one XON pause frame whose quanta field is 0.
- R4: A request raised while a client frame is in flight is held. The pause frame's start beat comes after that client frame's end beat, never between its start and end.
- R5: A pulse on `sw_xoff_set_i` or `sw_xon_set_i` raises the matching request. The matching readback output reads 1 from the next cycle and returns to 0 once a pause frame has started.
- R6: With `no_pause_fifo_i` low, a rising edge of `rx_almost_full_i` raises an XOFF request and a falling edge raises an XON request.
- R7: With `no_pause_fifo_i` high, edges of `rx_almost_full_i` produce no pause frame.
- R8: If both kinds are pending when the boundary is reached, only the most recently raised kind is sent, as a single frame. If both are raised in the same cycle, XOFF is sent.
- R9: The pause frame has the following format:
  - It is 8 beats long, with `tx_sop_o` on the first beat and `tx_eop_o` on the last. The last beat has `tx_empty_o` = 4.
  - Byte n of the frame sits on lane n mod 8, at bits [8*(n mod 8)+7 : 8*(n mod 8)] of beat n/8.
  - Bytes 0-5 are 01 80 C2 00 00 01.
  - Bytes 6-11 are `src_mac_i`, most significant byte first.
  - Bytes 12-15 are 88 08 00 01.
  - Bytes 16-17 are the quanta, most significant byte first.
  - Bytes 18-59 are zero.
- R10: `cl_ready_o` is low for exactly the 8 cycles in which pause beats are driven. Otherwise client valid, data, sop, eop and empty pass unchanged to the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cl_xoff_req_i | input | 1 | Client XOFF request strobe |
| cl_xon_req_i | input | 1 | Client XON request strobe |
| sw_xoff_set_i | input | 1 | Host write of 1 to the XOFF generate bit |
| sw_xon_set_i | input | 1 | Host write of 1 to the XON generate bit |
| sw_xoff_o | output | 1 | Readback of the self-clearing XOFF generate bit |
| sw_xon_o | output | 1 | Readback of the self-clearing XON generate bit |
| no_pause_fifo_i | input | 1 | Disables pause frames driven by the FIFO flag |
| rx_almost_full_i | input | 1 | Local receive FIFO almost-full flag |
| src_mac_i | input | 48 | Source address placed in pause frames |
| xoff_quanta_i | input | 16 | Pause time carried by XOFF frames |
| cl_valid_i | input | 1 | Client beat valid |
| cl_data_i | input | 64 | Client beat data, byte 0 in bits 7:0 |
| cl_sop_i | input | 1 | Client start of frame |
| cl_eop_i | input | 1 | Client end of frame |
| cl_empty_i | input | 3 | Unused bytes on the client end beat |
| cl_ready_o | output | 1 | Client may present a beat |
| tx_valid_o | output | 1 | Output beat valid |
| tx_data_o | output | 64 | Output beat data |
| tx_sop_o | output | 1 | Output start of frame |
| tx_eop_o | output | 1 | Output end of frame |
| tx_empty_o | output | 3 | Unused bytes on the output end beat |

## Verification
The bench raises requests in the middle of a multi-beat client frame and then checks that the pause start beat is later than the client end beat. A design that only looked at the current beat would splice the pause frame into the data. It lets an XOFF and an XON pile up behind one frame and also raises both in the same cycle. A design that queued both kinds, or picked the wrong one, would send two frames or the wrong quanta. It toggles the FIFO flag with the disable bit set, where a leaky edge detector would emit frames. It checks that the host bits clear only after a frame starts. Every pause frame is decoded byte by byte against the layout, so a lane-order or padding slip shows up as a format error. Counting the cycles in which ready is low catches an off-by-one beat count.

// File: rtl/eth_pause_pkg.sv
package eth_pause_pkg;
  typedef enum logic {PAUSE_XON = 1'b0, PAUSE_XOFF = 1'b1} pause_kind_e;

  localparam logic [47:0] PAUSE_DA     = 48'h0180C2000001;
  localparam logic [15:0] PAUSE_ETYPE  = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;

  // Byte idx of the pause frame in transmit order.
  function automatic logic [7:0] frame_byte(input int idx, input logic [47:0] sa,
                                            input logic [15:0] q);
    logic [7:0] b;
    if (idx < 6)        b = 8'(PAUSE_DA >> (8 * (5 - idx)));
    else if (idx < 12)  b = 8'(sa >> (8 * (11 - idx)));
    else if (idx == 12) b = PAUSE_ETYPE[15:8];
    else if (idx == 13) b = PAUSE_ETYPE[7:0];
    else if (idx == 14) b = PAUSE_OPCODE[15:8];
    else if (idx == 15) b = PAUSE_OPCODE[7:0];
    else if (idx == 16) b = q[15:8];
    else if (idx == 17) b = q[7:0];
    else                b = 8'h00;
    return b;
  endfunction
endpackage

// File: rtl/pause_req_merge.sv
module pause_req_merge
  import eth_pause_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cl_xoff_i,
  input  logic        cl_xon_i,
  input  logic        sw_xoff_set_i,
  input  logic        sw_xon_set_i,
  input  logic        no_pause_fifo_i,
  input  logic        rx_almost_full_i,
  input  logic        start_i,
  output logic        pend_o,
  output pause_kind_e kind_o,
  output logic        sw_xoff_o,
  output logic        sw_xon_o
);
  logic        af_q;
  logic        af_rise, af_fall;
  logic        raise_xoff, raise_xon;
  logic        pend_q;
  pause_kind_e kind_q;
  logic        sw_xoff_q, sw_xon_q;

  // Edge tracker runs even when disabled so re-enabling sees no stale edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) af_q <= 1'b0;
    else         af_q <= rx_almost_full_i;
  end

  assign af_rise    = rx_almost_full_i & ~af_q & ~no_pause_fifo_i;
  assign af_fall    = ~rx_almost_full_i & af_q & ~no_pause_fifo_i;
  assign raise_xoff = cl_xoff_i | sw_xoff_set_i | af_rise;
  assign raise_xon  = cl_xon_i  | sw_xon_set_i  | af_fall;

  // Single slot: latest raise overwrites the kind; XOFF wins a tie.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      kind_q <= PAUSE_XON;
    end else begin
      pend_q <= (pend_q & ~start_i) | raise_xoff | raise_xon;
      if (raise_xoff)     kind_q <= PAUSE_XOFF;
      else if (raise_xon) kind_q <= PAUSE_XON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_xoff_q <= 1'b0;
      sw_xon_q  <= 1'b0;
    end else begin
      if (sw_xoff_set_i) sw_xoff_q <= 1'b1;
      else if (start_i)  sw_xoff_q <= 1'b0;
      if (sw_xon_set_i)  sw_xon_q  <= 1'b1;
      else if (start_i)  sw_xon_q  <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign kind_o    = kind_q;
  assign sw_xoff_o = sw_xoff_q;
  assign sw_xon_o  = sw_xon_q;

  assert_nopause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (no_pause_fifo_i && !pend_q && !cl_xoff_i && !cl_xon_i && !sw_xoff_set_i && !sw_xon_set_i)
    |=> !pend_q);
  assert_hold_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !start_i) |=> pend_q);
  assert_sw_selfclear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !sw_xoff_set_i && !sw_xon_set_i) |=> (!sw_xoff_q && !sw_xon_q));
  assert_tie_xoff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_xoff_i && cl_xon_i) |=> (pend_q && kind_q == PAUSE_XOFF));
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import eth_pause_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int FRAME_BYTES = 60,
  localparam int BPB        = DATA_W / 8,
  localparam int EMPTY_W    = (BPB > 1) ? $clog2(BPB) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  pause_kind_e        kind_i,
  input  logic [47:0]        src_mac_i,
  input  logic [15:0]        quanta_i,
  output logic               busy_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               sop_o,
  output logic               eop_o,
  output logic [EMPTY_W-1:0] empty_o
);
  localparam int BEATS      = (FRAME_BYTES + BPB - 1) / BPB;
  localparam int CNT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LAST_EMPTY = BEATS * BPB - FRAME_BYTES;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       quanta_q;
  logic [47:0]       sa_q;
  logic              last_beat;

  assign last_beat = busy_q && (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      quanta_q <= '0;
      sa_q     <= '0;
    end else if (start_i && !busy_q) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      quanta_q <= (kind_i == PAUSE_XOFF) ? quanta_i : 16'h0000;
      sa_q     <= src_mac_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end

  for (genvar j = 0; j < BPB; j++) begin : g_lane
    always_comb begin
      data_o[8*j +: 8] = busy_q ? frame_byte(int'(cnt_q) * BPB + j, sa_q, quanta_q) : 8'h00;
    end
  end

  assign busy_o  = busy_q;
  assign sop_o   = busy_q && (cnt_q == '0);
  assign eop_o   = last_beat;
  assign empty_o = last_beat ? EMPTY_W'(LAST_EMPTY) : '0;

  assert_sop_follows_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> sop_o);
  assert_end_on_eop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(eop_o));
  assert_no_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_beat) |=> (busy_q && !sop_o));
endmodule

// File: rtl/pause_tx_mux.sv
module pause_tx_mux #(
  parameter int DATA_W  = 64,
  localparam int EMPTY_W = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cl_valid_i,
  input  logic [DATA_W-1:0]  cl_data_i,
  input  logic               cl_sop_i,
  input  logic               cl_eop_i,
  input  logic [EMPTY_W-1:0] cl_empty_i,
  output logic               cl_ready_o,
  input  logic               gen_busy_i,
  input  logic [DATA_W-1:0]  gen_data_i,
  input  logic               gen_sop_i,
  input  logic               gen_eop_i,
  input  logic [EMPTY_W-1:0] gen_empty_i,
  output logic               boundary_free_o,
  output logic               tx_valid_o,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic               tx_sop_o,
  output logic               tx_eop_o,
  output logic [EMPTY_W-1:0] tx_empty_o
);
  logic in_frame_q, in_frame_d, acc;

  assign cl_ready_o = ~gen_busy_i;
  assign acc        = cl_valid_i & cl_ready_o;

  always_comb begin
    in_frame_d = in_frame_q;
    if (acc && cl_eop_i)      in_frame_d = 1'b0;
    else if (acc && cl_sop_i) in_frame_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_frame_q <= 1'b0;
    else         in_frame_q <= in_frame_d;
  end

  assign boundary_free_o = ~in_frame_d;

  always_comb begin
    if (gen_busy_i) begin
      tx_valid_o = 1'b1;
      tx_data_o  = gen_data_i;
      tx_sop_o   = gen_sop_i;
      tx_eop_o   = gen_eop_i;
      tx_empty_o = gen_empty_i;
    end else begin
      tx_valid_o = cl_valid_i;
      tx_data_o  = cl_data_i;
      tx_sop_o   = cl_sop_i;
      tx_eop_o   = cl_eop_i;
      tx_empty_o = cl_empty_i;
    end
  end

  assert_pause_at_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_busy_i && gen_sop_i) |-> !in_frame_q);
  assert_frame_stays_closed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_busy_i |=> !in_frame_q);
endmodule

// File: rtl/eth_pause_ctrl.sv
module eth_pause_ctrl
  import eth_pause_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int FRAME_BYTES = 60,
  localparam int EMPTY_W    = (DATA_W / 8 > 1) ? $clog2(DATA_W / 8) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cl_xoff_req_i,
  input  logic               cl_xon_req_i,
  input  logic               sw_xoff_set_i,
  input  logic               sw_xon_set_i,
  output logic               sw_xoff_o,
  output logic               sw_xon_o,
  input  logic               no_pause_fifo_i,
  input  logic               rx_almost_full_i,
  input  logic [47:0]        src_mac_i,
  input  logic [15:0]        xoff_quanta_i,
  input  logic               cl_valid_i,
  input  logic [DATA_W-1:0]  cl_data_i,
  input  logic               cl_sop_i,
  input  logic               cl_eop_i,
  input  logic [EMPTY_W-1:0] cl_empty_i,
  output logic               cl_ready_o,
  output logic               tx_valid_o,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic               tx_sop_o,
  output logic               tx_eop_o,
  output logic [EMPTY_W-1:0] tx_empty_o
);
  logic               pend, busy, bfree, start;
  pause_kind_e        kind;
  logic [DATA_W-1:0]  g_data;
  logic               g_sop, g_eop;
  logic [EMPTY_W-1:0] g_empty;

  assign start = pend & ~busy & bfree;

  pause_req_merge u_merge (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cl_xoff_i        (cl_xoff_req_i),
    .cl_xon_i         (cl_xon_req_i),
    .sw_xoff_set_i    (sw_xoff_set_i),
    .sw_xon_set_i     (sw_xon_set_i),
    .no_pause_fifo_i  (no_pause_fifo_i),
    .rx_almost_full_i (rx_almost_full_i),
    .start_i          (start),
    .pend_o           (pend),
    .kind_o           (kind),
    .sw_xoff_o        (sw_xoff_o),
    .sw_xon_o         (sw_xon_o)
  );

  pause_frame_gen #(.DATA_W(DATA_W), .FRAME_BYTES(FRAME_BYTES)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .kind_i    (kind),
    .src_mac_i (src_mac_i),
    .quanta_i  (xoff_quanta_i),
    .busy_o    (busy),
    .data_o    (g_data),
    .sop_o     (g_sop),
    .eop_o     (g_eop),
    .empty_o   (g_empty)
  );

  pause_tx_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cl_valid_i      (cl_valid_i),
    .cl_data_i       (cl_data_i),
    .cl_sop_i        (cl_sop_i),
    .cl_eop_i        (cl_eop_i),
    .cl_empty_i      (cl_empty_i),
    .cl_ready_o      (cl_ready_o),
    .gen_busy_i      (busy),
    .gen_data_i      (g_data),
    .gen_sop_i       (g_sop),
    .gen_eop_i       (g_eop),
    .gen_empty_i     (g_empty),
    .boundary_free_o (bfree),
    .tx_valid_o      (tx_valid_o),
    .tx_data_o       (tx_data_o),
    .tx_sop_o        (tx_sop_o),
    .tx_eop_o        (tx_eop_o),
    .tx_empty_o      (tx_empty_o)
  );

  assert_pending_served_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !busy && bfree) |=> busy);
  assert_ready_back_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_eop_o) |=> cl_ready_o);
endmodule

// File: tb/eth_pause_ctrl_tb.sv
`timescale 1ns/1ps
module eth_pause_ctrl_tb;
  localparam logic [47:0] SA = 48'h021122334455;
  localparam logic [15:0] XQ = 16'h1234;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        xoff_r = 0, xon_r = 0, swxoff = 0, swxon = 0, nop = 0, af = 0;
  logic        swxoff_o, swxon_o;
  logic        cv = 0, cs = 0, ce = 0, crdy;
  logic [63:0] cd = '0;
  logic [2:0]  cemp = '0;
  logic        tv, ts, te;
  logic [63:0] td;
  logic [2:0]  temp;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, pause_cnt = 0, fmt_err = 0, ready_low = 0;
  int pause_sop_cyc = 0, client_eop_cyc = 0, beat = 0;
  logic        in_pause = 0;
  logic [15:0] last_q = '0;
  logic [63:0] bufr [8];

  always #2.5 clk = ~clk;

  eth_pause_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cl_xoff_req_i(xoff_r), .cl_xon_req_i(xon_r),
    .sw_xoff_set_i(swxoff), .sw_xon_set_i(swxon),
    .sw_xoff_o(swxoff_o), .sw_xon_o(swxon_o),
    .no_pause_fifo_i(nop), .rx_almost_full_i(af),
    .src_mac_i(SA), .xoff_quanta_i(XQ),
    .cl_valid_i(cv), .cl_data_i(cd), .cl_sop_i(cs), .cl_eop_i(ce), .cl_empty_i(cemp),
    .cl_ready_o(crdy),
    .tx_valid_o(tv), .tx_data_o(td), .tx_sop_o(ts), .tx_eop_o(te), .tx_empty_o(temp)
  );

  function automatic logic [7:0] exp_byte(input int i, input logic [15:0] q);
    logic [7:0] da [6];
    da = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6)  return da[i];
    if (i < 12) return SA[8*(11-i) +: 8];
    case (i)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h00;
      15: return 8'h01;
      16: return q[15:8];
      17: return q[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // Output monitor, sampled mid-cycle.
  always @(negedge clk) begin
    cyc++;
    if (!crdy) ready_low++;
    if (tv) begin
      if (ts && td[47:0] == 48'h010000C28001) begin
        in_pause = 1; beat = 0; pause_sop_cyc = cyc;
      end
      if (in_pause) begin
        if (beat < 8) bufr[beat] = td;
        if (te) begin
          logic [15:0] q;
          if (beat != 7 || temp != 3'd4) fmt_err++;
          q = {bufr[2][7:0], bufr[2][15:8]};
          for (int i = 0; i < 60; i++)
            if (bufr[i/8][8*(i%8) +: 8] != exp_byte(i, q)) fmt_err++;
          if (q != 16'h0 && q != XQ) fmt_err++;
          last_q = q; pause_cnt++; in_pause = 0;
        end else beat++;
      end else if (te) client_eop_cyc = cyc;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_beat(input logic [63:0] d, input logic s, input logic e);
    cv = 1; cd = d; cs = s; ce = e; cemp = e ? 3'd2 : 3'd0;
    do @(negedge clk); while (!crdy);
    @(posedge clk); #1;
    cv = 0; cs = 0; ce = 0; cemp = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; @(posedge clk); #1; sig = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; cycles(3); rst_n = 1; cycles(1);
    @(negedge clk);
    chk(crdy == 1, "R1 ready", crdy, 1);
    chk(tv == 0, "R1 valid", tv, 0);
    chk(swxoff_o == 0 && swxon_o == 0, "R1 sw bits", {swxoff_o, swxon_o}, 0);
    cycles(1);
  endtask

  task automatic t_client_xoff;
    int n0 = pause_cnt;
    pulse(xoff_r); cycles(15);
    chk(pause_cnt == n0 + 1, "R2 one xoff", pause_cnt - n0, 1);
    chk(last_q == XQ, "R2 quanta", last_q, XQ);
    chk(fmt_err == 0, "R9 format", fmt_err, 0);
  endtask

  task automatic t_client_xon;
    int n0 = pause_cnt;
    pulse(xon_r); cycles(15);
    chk(pause_cnt == n0 + 1, "R3 one xon", pause_cnt - n0, 1);
    chk(last_q == 0, "R3 quanta", last_q, 0);
  endtask

  task automatic t_defer;
    int n0 = pause_cnt;
    send_beat(64'hAAAA_0000_0000_0001, 1, 0);
    pulse(xoff_r);
    send_beat(64'hAAAA_0000_0000_0002, 0, 0);
    send_beat(64'hAAAA_0000_0000_0003, 0, 0);
    send_beat(64'hAAAA_0000_0000_0004, 0, 1);
    cycles(15);
    chk(pause_cnt == n0 + 1, "R4 frame sent", pause_cnt - n0, 1);
    chk(pause_sop_cyc > client_eop_cyc, "R4 after eop", pause_sop_cyc, client_eop_cyc + 1);
  endtask

  task automatic t_sw;
    int n0 = pause_cnt;
    pulse(swxon);
    @(negedge clk);
    chk(swxon_o == 1, "R5 xon bit set", swxon_o, 1);
    cycles(15);
    chk(swxon_o == 0, "R5 xon bit clear", swxon_o, 0);
    chk(pause_cnt == n0 + 1 && last_q == 0, "R5 xon frame", last_q, 0);
    pulse(swxoff);
    @(negedge clk);
    chk(swxoff_o == 1, "R5 xoff bit set", swxoff_o, 1);
    cycles(15);
    chk(swxoff_o == 0 && last_q == XQ, "R5 xoff frame", last_q, XQ);
  endtask

  task automatic t_fifo;
    int n0 = pause_cnt;
    af = 1; cycles(15);
    chk(pause_cnt == n0 + 1 && last_q == XQ, "R6 rise xoff", last_q, XQ);
    af = 0; cycles(15);
    chk(pause_cnt == n0 + 2 && last_q == 0, "R6 fall xon", pause_cnt - n0, 2);
  endtask

  task automatic t_nopause;
    int n0 = pause_cnt;
    nop = 1;
    af = 1; cycles(15); af = 0; cycles(15);
    chk(pause_cnt == n0, "R7 disabled", pause_cnt - n0, 0);
    nop = 0; cycles(5);
    chk(pause_cnt == n0, "R7 no stale edge", pause_cnt - n0, 0);
  endtask

  task automatic t_both;
    int n0 = pause_cnt;
    send_beat(64'hBBBB_0000_0000_0001, 1, 0);
    pulse(xoff_r);
    send_beat(64'hBBBB_0000_0000_0002, 0, 0);
    pulse(xon_r);
    send_beat(64'hBBBB_0000_0000_0003, 0, 1);
    cycles(25);
    chk(pause_cnt == n0 + 1, "R8 single frame", pause_cnt - n0, 1);
    chk(last_q == 0, "R8 latest xon", last_q, 0);
    xoff_r = 1; xon_r = 1; @(posedge clk); #1; xoff_r = 0; xon_r = 0;
    cycles(25);
    chk(pause_cnt == n0 + 2 && last_q == XQ, "R8 tie xoff", last_q, XQ);
  endtask

  task automatic t_ready;
    int r0 = ready_low;
    pulse(xoff_r); cycles(15);
    chk(ready_low - r0 == 8, "R10 ready low beats", ready_low - r0, 8);
    cv = 1; cd = 64'hC0DE_1234_5678_9ABC; cs = 1; ce = 1; cemp = 3'd5;
    @(negedge clk);
    chk(tv && td == 64'hC0DE_1234_5678_9ABC && ts && te && temp == 3'd5,
        "R10 passthrough", td, 64'hC0DE_1234_5678_9ABC);
    @(posedge clk); #1; cv = 0; cs = 0; ce = 0; cemp = 0;
    cycles(2);
    chk(fmt_err == 0, "R9 format all", fmt_err, 0);
  endtask

  initial begin
    t_reset();
    t_client_xoff();
    t_client_xon();
    t_defer();
    t_sw();
    t_fifo();
    t_nopause();
    t_both();
    t_ready();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule